// File: doc/BRIEF.md
# Programmable Register-Write Sequencer

This block sits on a local register write bus, between the host and the registers the host drives. Every host write is forwarded to the output bus after one register stage. On a rising edge of the trigger input, the block also replays a stored program of timed register writes onto the same output bus. The output therefore carries host traffic and sequencer traffic merged onto one bus.

The program is held in a two-bank table of 32-bit words. The host loads the inactive bank with ordinary bus writes, qualified by a select strobe that an external address decoder produces. The host then toggles a bank-select input, and the freshly loaded bank becomes active once the sequencer is idle. A program is a list of steps. Each step holds a wait length, a target register address and a 32-bit value split into two halves. A step with target address zero ends the run.

The host always has priority on the output bus. A sequencer write that meets a host write in the same cycle is lost. The block reports that loss with a one-cycle collision pulse and with a sticky status bit.

Top module: `regwr_sequencer`

## Requirements
- R1: A host write (host_we high) appears on the output bus exactly one cycle later, with out_we high and the same address and data. A cycle without any write source gives out_we low one cycle later.
- R2: When a host write and a sequencer write fall in the same cycle, the output bus carries the host write and the sequencer write is dropped.
- R3: A dropped sequencer write drives collision high for exactly one cycle, in the cycle in which the output bus carries the winning host write. Status bit 2 then stays set until the next run start clears it.
- R4: Step n occupies table words 4n to 4n+3, in this order:
  - word 4n: wait length, in bits [DLYW-1:0];
  - word 4n+1: target address, in bits [AW-1:0];
  - word 4n+2: low data half, in bits [15:0];
  - word 4n+3: high data half, in bits [15:0].

  The issued write carries the data {high half, low half}.
- R5: The write of the first step appears on the output bus 5 cycles after the clock edge that samples the trigger edge. Each later step's write follows the previous one by 4 + wait × 2^GRAN cycles.
- R6: A step whose target address is zero issues no write and ends the run. The running flag (status bit 1) drops 4 cycles after that step begins. The next run starts again from step 0.
- R7: A host write with tbl_sel high stores host_data at word host_addr[TAW-1:0] of the inactive bank only. The active bank follows the bank_sel input and is reported on status bit 0.
- R8: A change of bank_sel during a run is deferred. The active bank changes on the first edge at which the sequencer is idle.
- R9: A run starts only on a rising edge of trig. An edge during a run is ignored, and a trigger held high starts only one run.
- R10: Status bits are {armed, collision seen, running, active bank}, from bit 3 down to bit 0. The armed bit is 1 when the sequencer is idle and the last sampled trig is low. After reset, status is 4'b1000 and out_we and collision are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig | input | 1 | Run trigger; its rising edge is used |
| host_we | input | 1 | Host write strobe |
| host_addr | input | AW | Host write address |
| host_data | input | DW | Host write data |
| tbl_sel | input | 1 | From the external decoder: the host write targets the program table |
| bank_sel | input | 1 | Requested active bank; toggled after loading |
| out_we | output | 1 | Merged output write strobe |
| out_addr | output | AW | Merged output address |
| out_data | output | DW | Merged output data |
| collision | output | 1 | One-cycle pulse when a sequencer write is dropped |
| status | output | 4 | {armed, collision seen, running, active bank} |

## Verification
A host write and a sequencer write can land in the same cycle, and only one of them can reach the output bus. The bench provokes this by placing a host write exactly in the issue cycle of the first program step, 4 cycles after the trigger is sampled. It then checks three things:
- the output bus in the following cycle carries the host address and data;
- collision is high in that cycle only, and the sticky status bit rises one cycle later;
- the second step's write still lands at its scheduled cycle.

// File: rtl/seq_pkg.sv
// Shared types for the register-write sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package seq_pkg;

    // Sequencer control states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_t;

endpackage

// File: rtl/seq_table.sv
// Two-bank program store with one write port and one registered read port.
// The write port and the read port take separate bank bits. The caller
// keeps them on opposite banks, so a word is never read and written in
// the same cycle. Memory contents are not reset.
module seq_table #(
    parameter int DW  = 32,
    parameter int TAW = 10
) (
    input  logic           clk,
    input  logic           wr_en,
    input  logic           wr_bank,
    input  logic [TAW-1:0] wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic           rd_bank,
    input  logic [TAW-1:0] rd_addr,
    output logic [DW-1:0]  rd_data
);
    localparam int DEPTH = 2 ** (TAW + 1);

    logic [DW-1:0] mem [DEPTH];

    // Store a host word into the addressed bank.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[{wr_bank, wr_addr}] <= wr_data;
        end
    end

    // Registered read of the active bank.
    always_ff @(posedge clk) begin
        rd_data <= mem[{rd_bank, rd_addr}];
    end

endmodule

// File: rtl/seq_engine.sv
// Program engine: detects the trigger edge, walks the steps of the active
// bank, issues one write request per step and times the wait between steps.
// It owns the active-bank register and moves it only while idle.
// Assumes: a table read latency of one cycle, DW is even, and AW < DW.
module seq_engine
    import seq_pkg::*;
#(
    parameter int AW   = 17,
    parameter int DW   = 32,
    parameter int TAW  = 10,
    parameter int DLYW = 16,
    parameter int GRAN = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           trig,
    input  logic           bank_req,
    input  logic [DW-1:0]  rd_data,
    output logic [TAW-1:0] rd_addr,
    output logic           act_bank,
    output logic           req_we,
    output logic [AW-1:0]  req_addr,
    output logic [DW-1:0]  req_data,
    output logic           run_start,
    output logic           running,
    output logic           armed
);
    localparam int PCW = TAW - 2;
    localparam int CW  = DLYW + GRAN;
    localparam int HW  = DW / 2;

    seq_state_t      state;
    logic [1:0]      ph;
    logic [PCW-1:0]  pc;
    logic [CW-1:0]   cnt;
    logic [DLYW-1:0] dly;
    logic [AW-1:0]   tgt;
    logic [HW-1:0]   lo;
    logic            pend;
    logic            trig_q;
    logic            unused_bits;

    // Start condition: a fresh trigger edge while idle.
    always_comb begin
        run_start = trig && !trig_q && (state == ST_IDLE);
    end

    // Table read address and the outgoing request of the issue cycle.
    always_comb begin
        rd_addr  = {pc, ph};
        req_we   = pend;
        req_addr = tgt;
        req_data = {rd_data[HW-1:0], lo};
        running  = (state != ST_IDLE);
        armed    = (state == ST_IDLE) && !trig_q;
    end

    assign unused_bits = ^rd_data[DW-1:AW];

    // Trigger history and bank swap, the latter held back while a run is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q   <= 1'b0;
            act_bank <= 1'b0;
        end else begin
            trig_q <= trig;
            if ((state == ST_IDLE) && !run_start && (bank_req != act_bank)) begin
                act_bank <= bank_req;
            end
        end
    end

    // Step sequencing: four fetch phases, an optional wait, then the next step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ph    <= 2'd0;
            pc    <= '0;
            cnt   <= '0;
            dly   <= '0;
            tgt   <= '0;
            lo    <= '0;
            pend  <= 1'b0;
        end else begin
            pend <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (run_start) begin
                        state <= ST_FETCH;
                        ph    <= 2'd0;
                        pc    <= '0;
                    end
                end
                ST_FETCH: begin
                    ph <= ph + 2'd1;
                    if (ph == 2'd1) dly <= rd_data[DLYW-1:0];
                    if (ph == 2'd2) tgt <= rd_data[AW-1:0];
                    if (ph == 2'd3) begin
                        lo <= rd_data[HW-1:0];
                        if (tgt == '0) begin
                            state <= ST_IDLE;
                            pc    <= '0;
                        end else begin
                            pend <= 1'b1;
                            if (dly == '0) begin
                                pc <= pc + PCW'(1);
                            end else begin
                                state <= ST_WAIT;
                                cnt   <= CW'(dly) << GRAN;
                            end
                        end
                    end
                end
                ST_WAIT: begin
                    if (cnt == CW'(1)) begin
                        state <= ST_FETCH;
                        pc    <= pc + PCW'(1);
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_SWAP_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (act_bank == $past(act_bank)))
        else $error("bank changed during a run"); // R8

    AST_NO_ZERO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> (tgt != '0))
        else $error("write issued to address zero"); // R6

    AST_START_AT_STEP0: assert property (@(posedge clk) disable iff (!rst_n)
        run_start |=> (state == ST_FETCH && ph == 2'd0 && pc == '0))
        else $error("run did not begin at step 0"); // R9

    AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH && ph != 2'd3) |=> (state == ST_FETCH && ph == $past(ph) + 2'd1))
        else $error("fetch phase skipped"); // R5

endmodule

// File: rtl/seq_bus_merge.sv
// Output stage: registers the merged write bus. A host write has priority
// over a sequencer request; the losing request raises a one-cycle collision flag.
// Assumes: the two sources are single-cycle strobes.
module seq_bus_merge #(
    parameter int AW = 17,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_data,
    input  logic          seq_we,
    input  logic [AW-1:0] seq_addr,
    input  logic [DW-1:0] seq_data,
    output logic          out_we,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_data,
    output logic          collision
);

    // Pick the winning source and register it onto the output bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_we    <= 1'b0;
            out_addr  <= '0;
            out_data  <= '0;
            collision <= 1'b0;
        end else begin
            out_we    <= host_we || seq_we;
            out_addr  <= host_we ? host_addr : seq_addr;
            out_data  <= host_we ? host_data : seq_data;
            collision <= host_we && seq_we;
        end
    end

    AST_HOST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        host_we |=> (out_we && out_addr == $past(host_addr) && out_data == $past(host_data)))
        else $error("host write not forwarded"); // R1

    AST_SEQ_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_we && !host_we) |=> (out_we && out_addr == $past(seq_addr) && !collision))
        else $error("sequencer write not forwarded"); // R4

    AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && seq_we) |=> (collision && out_data == $past(host_data)))
        else $error("contention not resolved for host"); // R2

    AST_COLL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        collision |=> !collision)
        else $error("collision longer than one cycle"); // R3

endmodule

// File: rtl/regwr_sequencer.sv
// Top level: forwards host writes with one cycle of latency, stores the
// two-bank program, replays it on a trigger edge and reports status.
// Assumes: tbl_sel is decoded externally and is valid together with host_we.
module regwr_sequencer #(
    parameter int AW   = 17,
    parameter int DW   = 32,
    parameter int TAW  = 10,
    parameter int DLYW = 16,
    parameter int GRAN = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_data,
    input  logic          tbl_sel,
    input  logic          bank_sel,
    output logic          out_we,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_data,
    output logic          collision,
    output logic [3:0]    status
);
    logic [DW-1:0]  rd_data;
    logic [TAW-1:0] rd_addr;
    logic           act_bank;
    logic           req_we;
    logic [AW-1:0]  req_addr;
    logic [DW-1:0]  req_data;
    logic           run_start;
    logic           running;
    logic           armed;
    logic           coll_seen;
    logic           tbl_we;

    assign tbl_we = host_we && tbl_sel;

    seq_table #(.DW(DW), .TAW(TAW)) i_table (
        .clk     (clk),
        .wr_en   (tbl_we),
        .wr_bank (!act_bank),
        .wr_addr (host_addr[TAW-1:0]),
        .wr_data (host_data),
        .rd_bank (act_bank),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    seq_engine #(.AW(AW), .DW(DW), .TAW(TAW), .DLYW(DLYW), .GRAN(GRAN)) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .bank_req  (bank_sel),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .act_bank  (act_bank),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .run_start (run_start),
        .running   (running),
        .armed     (armed)
    );

    seq_bus_merge #(.AW(AW), .DW(DW)) i_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (host_we),
        .host_addr (host_addr),
        .host_data (host_data),
        .seq_we    (req_we),
        .seq_addr  (req_addr),
        .seq_data  (req_data),
        .out_we    (out_we),
        .out_addr  (out_addr),
        .out_data  (out_data),
        .collision (collision)
    );

    // Sticky record of lost sequencer writes, cleared when a run starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coll_seen <= 1'b0;
        end else if (run_start) begin
            coll_seen <= 1'b0;
        end else if (collision) begin
            coll_seen <= 1'b1;
        end
    end

    assign status = {armed, coll_seen, running, act_bank};

    AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (collision && !run_start) |=> status[2])
        else $error("collision not recorded"); // R3

    AST_ARMED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] |-> !status[3])
        else $error("armed while running"); // R10

endmodule

// File: tb/test_regwr_sequencer.sv
module test_regwr_sequencer;
    localparam int AW = 17;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig = 1'b0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_data = '0;
    logic          tbl_sel = 1'b0;
    logic          bank_sel = 1'b0;
    logic          out_we, collision;
    logic [AW-1:0] out_addr;
    logic [DW-1:0] out_data;
    logic [3:0]    status;
    logic          out_we_g, collision_g;
    logic [AW-1:0] out_addr_g;
    logic [DW-1:0] out_data_g;
    logic [3:0]    status_g;

    regwr_sequencer #(.AW(AW), .DW(DW)) i_regwr_sequencer (
        .clk(clk), .rst_n(rst_n), .trig(trig), .host_we(host_we),
        .host_addr(host_addr), .host_data(host_data), .tbl_sel(tbl_sel),
        .bank_sel(bank_sel), .out_we(out_we), .out_addr(out_addr),
        .out_data(out_data), .collision(collision), .status(status)
    );

    regwr_sequencer #(.AW(AW), .DW(DW), .GRAN(1)) i_regwr_sequencer_g1 (
        .clk(clk), .rst_n(rst_n), .trig(trig), .host_we(host_we),
        .host_addr(host_addr), .host_data(host_data), .tbl_sel(tbl_sel),
        .bank_sel(bank_sel), .out_we(out_we_g), .out_addr(out_addr_g),
        .out_data(out_data_g), .collision(collision_g), .status(status_g)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    int            nrec, nrec_g, ncoll;
    int            rec_t [8];
    logic [AW-1:0] rec_a [8];
    logic [DW-1:0] rec_d [8];
    int            rec_tg [8];
    logic [3:0]    st_hist [64];
    logic          coll_hist [64];

    // {we, addr, data} pass-through vectors
    localparam logic [49:0] VEC [6] = '{
        {1'b1, 17'h00010, 32'h11111111},
        {1'b0, 17'h00020, 32'h22222222},
        {1'b1, 17'h1FFFF, 32'hA5A5A5A5},
        {1'b1, 17'h00001, 32'h00000000},
        {1'b0, 17'h00000, 32'hFFFFFFFF},
        {1'b1, 17'h0AAAA, 32'hFFFFFFFF}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic sel);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_data = d; tbl_sel = sel;
        @(negedge clk);
        host_we = 1'b0; tbl_sel = 1'b0;
    endtask

    task automatic load_step(input int idx, input logic [15:0] dly, input logic [AW-1:0] tgt,
                             input logic [15:0] lo, input logic [15:0] hi);
        host_wr(AW'(idx * 4 + 0), DW'(dly), 1'b1);
        host_wr(AW'(idx * 4 + 1), DW'(tgt), 1'b1);
        host_wr(AW'(idx * 4 + 2), {16'hF00D, lo}, 1'b1);
        host_wr(AW'(idx * 4 + 3), {16'hBAD0, hi}, 1'b1);
    endtask

    // Raise trig at a negedge; rel counts edges from the sampling edge.
    task automatic capture(input int n, input int trig_off, input int retrig_on,
                           input int retrig_off, input int host_at, input int bank_at);
        int c0;
        @(negedge clk);
        trig = 1'b1;
        c0 = cyc + 1;
        nrec = 0; nrec_g = 0; ncoll = 0;
        for (int k = 0; k < n; k++) begin
            int rel;
            @(negedge clk);
            rel = cyc - c0;
            if (rel >= 0 && rel < 64) begin
                st_hist[rel] = status;
                coll_hist[rel] = collision;
            end
            if (collision) ncoll++;
            if (out_we && nrec < 8) begin
                rec_t[nrec] = rel; rec_a[nrec] = out_addr; rec_d[nrec] = out_data; nrec++;
            end
            if (out_we_g && nrec_g < 8) begin
                rec_tg[nrec_g] = rel; nrec_g++;
            end
            if (rel == trig_off)   trig = 1'b0;
            if (rel == retrig_on)  trig = 1'b1;
            if (rel == retrig_off) trig = 1'b0;
            if (host_at >= 0 && rel == host_at) begin
                host_we = 1'b1; host_addr = 17'h00055; host_data = 32'hCAFEF00D; tbl_sel = 1'b0;
            end
            if (host_at >= 0 && rel == host_at + 1) host_we = 1'b0;
            if (rel == bank_at) bank_sel = ~bank_sel;
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        // Reset state (R10)
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R10 reset status", 64'(status), 64'h8);
        chk("R10 reset out_we", 64'(out_we), 64'h0);
        chk("R10 reset collision", 64'(collision), 64'h0);

        // Pass-through vectors (R1)
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            host_we = VEC[i][49]; host_addr = VEC[i][48:32]; host_data = VEC[i][31:0];
            @(negedge clk);
            chk("R1 out_we", 64'(out_we), 64'(VEC[i][49]));
            if (VEC[i][49]) begin
                chk("R1 out_addr", 64'(out_addr), 64'(VEC[i][48:32]));
                chk("R1 out_data", 64'(out_data), 64'(VEC[i][31:0]));
            end
        end
        host_we = 1'b0;

        // Load program into inactive bank 1, then swap (R4, R7)
        load_step(0, 16'd2, 17'h00123, 16'hBEEF, 16'hDEAD);
        load_step(1, 16'd0, 17'h1ABCD, 16'h5678, 16'h1234);
        load_step(2, 16'd0, 17'h00000, 16'h0000, 16'h0000);
        @(negedge clk);
        bank_sel = 1'b1;
        @(negedge clk);
        chk("R7 active bank after toggle", 64'(status[0]), 64'h1);

        // Run with a retrigger pulse mid-run (R4, R5, R6, R9)
        capture(24, 1, 3, 5, -1, -1);
        chk("R9 retrigger ignored: write count", 64'(nrec), 64'd2);
        chk("R5 step0 time", 64'(rec_t[0]), 64'd5);
        chk("R4 step0 addr", 64'(rec_a[0]), 64'h00123);
        chk("R4 step0 data", 64'(rec_d[0]), 64'hDEADBEEF);
        chk("R5 step1 time", 64'(rec_t[1]), 64'd11);
        chk("R4 step1 addr", 64'(rec_a[1]), 64'h1ABCD);
        chk("R4 step1 data", 64'(rec_d[1]), 64'h12345678);
        chk("R6 running before end", 64'(st_hist[13][1]), 64'h1);
        chk("R6 running after end", 64'(st_hist[14][1]), 64'h0);
        chk("R5 GRAN=1 write count", 64'(nrec_g), 64'd2);
        chk("R5 GRAN=1 step1 time", 64'(rec_tg[1]), 64'd13);

        // Host write in the issue cycle of step 0 (R2, R3)
        capture(24, 1, -1, -1, 4, -1);
        chk("R2 write count", 64'(nrec), 64'd2);
        chk("R2 host wins addr", 64'(rec_a[0]), 64'h00055);
        chk("R2 host wins data", 64'(rec_d[0]), 64'hCAFEF00D);
        chk("R2 host write time", 64'(rec_t[0]), 64'd5);
        chk("R2 step1 unaffected", 64'(rec_d[1]), 64'h12345678);
        chk("R3 collision pulse cycle", 64'(coll_hist[5]), 64'h1);
        chk("R3 collision single cycle", 64'(ncoll), 64'd1);
        chk("R3 sticky set", 64'(st_hist[6][2]), 64'h1);
        chk("R3 sticky held", 64'(status[2]), 64'h1);

        // Held-high trigger and sticky clear (R9, R3, R10)
        capture(40, -1, -1, -1, -1, -1);
        chk("R3 sticky cleared at start", 64'(st_hist[0][2]), 64'h0);
        chk("R9 held trigger single run", 64'(nrec), 64'd2);
        chk("R6 restart from step 0", 64'(rec_a[0]), 64'h00123);
        chk("R10 not armed while trig high", 64'(st_hist[30][3]), 64'h0);
        trig = 1'b0;
        @(negedge clk);
        chk("R10 armed after trig low", 64'(status), 64'h9);

        // Bank 0 program that ends at once; swap requested during a run (R7, R8, R6)
        load_step(0, 16'd7, 17'h00000, 16'h1111, 16'h2222);
        capture(24, 1, -1, -1, -1, 2);
        chk("R7 inactive-bank writes left active program intact", 64'(nrec), 64'd2);
        chk("R8 bank held during run", 64'(st_hist[14][0]), 64'h1);
        chk("R8 bank swapped when idle", 64'(st_hist[15][0]), 64'h0);
        capture(12, 1, -1, -1, -1, -1);
        chk("R6 zero target issues nothing", 64'(nrec), 64'd0);
        chk("R6 running in last phase", 64'(st_hist[3][1]), 64'h1);
        chk("R6 idle after zero step", 64'(st_hist[4][1]), 64'h0);

        done = 1'b1;
        report();
        $finish;
    end
endmodule